// File: doc/BRIEF.md
# Triggered Parallel Pattern Capture Engine

This block records a 32-bit parallel input bus into an on-chip FIFO once software has armed it and a trigger edge has been seen. Software picks which trigger edge counts: rising or falling. Software also picks the sample clock from four sources: a fast internal divided rate, a slow internal divided rate, a pacer tick from a timer elsewhere on the chip, or an external strobe. When the strobe is the source, the block can also answer each accepted sample with an acknowledge pulse.

Samples can be 8, 16 or 32 bits wide. Narrow samples are packed into 32-bit FIFO words. A capture ends by itself after a programmed number of samples. At that point a partly filled word is written with zeros in its unused lanes, and a done flag is raised.

The trigger and the strobe are asynchronous. Both pass through two-flop synchronisers before the core uses them. The data bus is delayed by the same two stages, so each sample stays aligned with its strobe.

A DMA engine drains the FIFO through a show-ahead read port. If a word arrives while the FIFO is full, the word is dropped and a sticky overflow flag is set. Only a software write clears that flag.

Top module: `pattern_capture`

## Requirements
- R1: Writing 1 to control bit 0 (register 0) arms the block. Capture then starts at the next synchronised trigger edge of the chosen polarity: control bit 1 = 0 selects rising, 1 selects falling. Edges of the other polarity, and trigger edges that come while the block is not armed, have no effect.
- R2: Control bits [3:2] choose the sample clock:
  - 0: one sample every DIV_FAST core cycles.
  - 1: one sample every DIV_SLOW core cycles.
  - 2: one sample per `pacer_tick_i` pulse.
  - 3: one sample per synchronised rising edge of `ext_req_i`.
- R3: Control bits [5:4] set the sample width:
  - 0: din[7:0], four samples per word.
  - 1: din[15:0], two samples per word.
  - 2 or 3: the full 32 bits, one sample per word.
  - The first sample of a word goes in the lowest lane.
- R4: Register 1 holds the sample count N. A capture stores exactly N samples, then stops and sets done (status register 2, bit 0). A new arm clears done.
- R5: When the capture stops with a partly filled word, that word is written to the FIFO with zeros in its unused upper lanes.
- R6: When control bit 6 is set and the strobe is the sample source, `ack_o` gives one one-cycle pulse per accepted sample. In every other case `ack_o` stays low.
- R7: The FIFO read port is show-ahead. `rd_valid_o` is high when the FIFO holds data, `rd_data_o` shows the oldest word, and `rd_en_i` removes it. Words leave in the order they were captured.
- R8: A word that arrives while the FIFO is full is dropped, and overflow (status bit 1) sets. Overflow stays set until software writes 1 to bit 1 of register 2.
- R9: The trigger and the strobe are synchronised by two flops. Any pulse at least two core cycles wide is detected, which covers 32 ns for any core clock period up to 16 ns.
- R10: After reset:
  - the FIFO is empty;
  - `ack_o` is low;
  - status register 2 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 32 | Raw parallel input bus |
| trig_i | input | 1 | Asynchronous capture trigger |
| ext_req_i | input | 1 | Asynchronous external sample strobe |
| pacer_tick_i | input | 1 | One-cycle pacer tick in the core clock domain |
| ack_o | output | 1 | Handshake acknowledge pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 count, 2 status, 3 samples taken |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| rd_en_i | input | 1 | FIFO pop |
| rd_data_o | output | 32 | Oldest FIFO word |
| rd_valid_o | output | 1 | FIFO not empty |

## Verification
The bench uses byte-wide captures whose length is not a multiple of four. These show whether the design pads the last word with zeros and keeps the upper bus bits out of the narrow lanes. A design that got this wrong would either never write the final word or leave old data in it.

The bench arms with falling polarity and then drives a rising edge. A design that ignored the polarity setting would start capturing at that rising edge.

The bench pushes ten words into an eight-word FIFO. It then checks that the first eight words survive in order and that the overflow flag stays set after the FIFO is drained, until software clears it. A design that overwrote old words or cleared the flag when the FIFO drained would fail here.

The bench also counts acknowledge pulses with the handshake on and off, and checks that the slow internal rate takes clearly longer than the fast one.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {SRC_FAST, SRC_SLOW, SRC_PACER, SRC_EXT} src_e;
  typedef enum logic [1:0] {WID_8, WID_16, WID_32, WID_32B} wid_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN, ST_RSVD} st_e;
  localparam int WORD_W = 32;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_TAKEN = 2'd3;
endpackage

// File: rtl/pc_sync_edge.sv
module pc_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= a_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;

  p_rise_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_rise_fall_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/pc_tick_sel.sv
module pc_tick_sel
  import pc_pkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic pacer_i,
  input  logic ext_rise_i,
  output logic tick_o
);
  logic [1:0] div_tick;

  for (genvar g = 0; g < 2; g++) begin : g_div
    localparam int D  = (g == 0) ? DIV_FAST : DIV_SLOW;
    localparam int CW = (D > 1) ? $clog2(D) : 1;
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (cnt_q == CW'(D - 1)) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
    assign div_tick[g] = (cnt_q == CW'(D - 1));
  end

  always_comb begin
    unique case (src_i)
      SRC_FAST:  tick_o = div_tick[0];
      SRC_SLOW:  tick_o = div_tick[1];
      SRC_PACER: tick_o = pacer_i;
      default:   tick_o = ext_rise_i;
    endcase
  end

  p_ext_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_EXT) |-> (tick_o == ext_rise_i));
endmodule

// File: rtl/pc_packer.sv
module pc_packer
  import pc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  wid_e              wid_i,
  input  logic              smp_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q, ins, nxt;
  logic [1:0]        idx_q;
  logic              full;

  always_comb begin
    unique case (wid_i)
      WID_8: begin
        ins  = WORD_W'(data_i[7:0]) << {idx_q, 3'b000};
        full = (idx_q == 2'd3);
      end
      WID_16: begin
        ins  = WORD_W'(data_i[15:0]) << {idx_q[0], 4'b0000};
        full = idx_q[0];
      end
      default: begin
        ins  = data_i;
        full = 1'b1;
      end
    endcase
    nxt = acc_q | ins;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      idx_q      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (clr_i) begin
        acc_q <= '0;
        idx_q <= '0;
      end else if (smp_i) begin
        if (full || last_i) begin
          word_o     <= nxt;
          word_vld_o <= 1'b1;
          acc_q      <= '0;
          idx_q      <= '0;
        end else begin
          acc_q <= nxt;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  p_emit_on_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && last_i && !clr_i) |=> word_vld_o);
  p_w32_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && wid_i[1] && !clr_i) |=> (word_vld_o && word_o == $past(data_i)));
  p_idle_no_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_i |=> !word_vld_o);
endmodule

// File: rtl/pc_fifo.sv
module pc_fifo #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          valid_o,
  output logic          full_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_pop  = pop_i && valid_o;
  assign do_push = push_i && !full_o;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  p_full_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == $past(cnt_q)));
  p_empty_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && pop_i && !push_i) |=> !valid_o);
endmodule

// File: rtl/pattern_capture.sv
module pattern_capture
  import pc_pkg::*;
#(
  parameter int FIFO_AW  = 11,
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] din_i,
  input  logic        trig_i,
  input  logic        ext_req_i,
  input  logic        pacer_tick_i,
  output logic        ack_o,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        rd_en_i,
  output logic [31:0] rd_data_o,
  output logic        rd_valid_o
);
  logic        pol_q, hs_q, done_q, ovf_q;
  src_e        src_q;
  wid_e        wid_q;
  st_e         st_q;
  logic [31:0] n_q, taken_q;
  logic [31:0] d1_q, d2_q;
  logic        arm, ovf_clr, trig_rise, trig_fall, trig_edge, ext_rise;
  logic        tick, take, last;
  logic        word_vld, fifo_full;
  logic [31:0] word;

  assign arm     = reg_we_i && (reg_addr_i == A_CTRL) && reg_wdata_i[0];
  assign ovf_clr = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= 1'b0;
      hs_q  <= 1'b0;
      src_q <= SRC_FAST;
      wid_q <= WID_32;
      n_q   <= 32'd1;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_CTRL) begin
        pol_q <= reg_wdata_i[1];
        src_q <= src_e'(reg_wdata_i[3:2]);
        wid_q <= wid_e'(reg_wdata_i[5:4]);
        hs_q  <= reg_wdata_i[6];
      end
      if (reg_addr_i == A_CNT) n_q <= reg_wdata_i;
    end
  end

  // data delayed to stay aligned with the synchronised strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q <= '0;
      d2_q <= '0;
    end else begin
      d1_q <= din_i;
      d2_q <= d1_q;
    end
  end

  pc_sync_edge u_trig (
    .clk_i (clk_i), .rst_ni(rst_ni), .a_i(trig_i),
    .rise_o(trig_rise), .fall_o(trig_fall)
  );

  logic ext_fall;
  pc_sync_edge u_ext (
    .clk_i (clk_i), .rst_ni(rst_ni), .a_i(ext_req_i),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  assign trig_edge = pol_q ? trig_fall : trig_rise;

  pc_tick_sel #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_q),
    .pacer_i(pacer_tick_i), .ext_rise_i(ext_rise), .tick_o(tick)
  );

  assign take = (st_q == ST_RUN) && tick;
  assign last = (taken_q == n_q - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      taken_q <= '0;
      done_q  <= 1'b0;
      ack_o   <= 1'b0;
    end else begin
      ack_o <= take && hs_q && (src_q == SRC_EXT);
      if (arm) begin
        st_q    <= ST_ARMED;
        taken_q <= '0;
        done_q  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ARMED: if (trig_edge) st_q <= ST_RUN;
          ST_RUN: if (take) begin
            taken_q <= taken_q + 32'd1;
            if (last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  pc_packer u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(arm), .wid_i(wid_q),
    .smp_i(take), .last_i(last), .data_i(d2_q),
    .word_vld_o(word_vld), .word_o(word)
  );

  pc_fifo #(.AW(FIFO_AW), .DW(WORD_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(word_vld), .din_i(word),
    .pop_i(rd_en_i), .dout_o(rd_data_o), .valid_o(rd_valid_o), .full_o(fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (word_vld && fifo_full) ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = {25'd0, hs_q, wid_q, src_q, pol_q, 1'b0};
      A_CNT:   reg_rdata_o = n_q;
      A_STAT:  reg_rdata_o = {28'd0, ext_fall & 1'b0, (st_q != ST_IDLE), ovf_q, done_q};
      default: reg_rdata_o = taken_q;
    endcase
  end

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);
  p_ack_follows_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(st_q == ST_RUN && src_q == SRC_EXT && hs_q));
  p_armed_wait_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && !trig_edge && !arm) |=> (st_q == ST_ARMED));
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (st_q == ST_IDLE));
endmodule

// File: tb/sim_pattern_capture.sv
module sim_pattern_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] din_i = '0;
  logic        trig_i = 1'b0;
  logic        ext_req_i = 1'b0;
  logic        pacer_tick_i = 1'b0;
  logic        ack_o;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;

  int n_chk = 0, n_fail = 0, ack_tot = 0;
  logic [31:0] got [0:15];
  int got_n;
  logic bench_done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) if (ack_o) ack_tot++;

  pattern_capture #(.FIFO_AW(3), .DIV_FAST(2), .DIV_SLOW(4)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // ctrl: bit1 pol, [3:2] src, [5:4] width, bit6 handshake
  function automatic logic [31:0] ctrl(input bit pol, input int src, input int wid, input bit hs);
    return {25'd0, hs, 2'(wid), 2'(src), pol, 1'b0};
  endfunction

  task automatic setup(input bit pol, input int src, input int wid, input bit hs, input int n);
    wr(2'd0, ctrl(pol, src, wid, hs));
    wr(2'd1, 32'(n));
    wr(2'd0, ctrl(pol, src, wid, hs) | 32'd1);
  endtask

  task automatic trig_pulse(input int w);
    trig_i = 1'b1; step(w); trig_i = 1'b0; step(4);
  endtask

  task automatic strobe(input logic [31:0] v);
    din_i = v; step(2);
    ext_req_i = 1'b1; step(3);
    ext_req_i = 1'b0; step(3);
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] s;
    cyc = 0;
    do begin rd(2'd2, s); cyc++; end while (!s[0] && cyc < 500);
  endtask

  task automatic drain();
    got_n = 0;
    forever begin
      @(negedge clk_i);
      if (!rd_valid_o || got_n >= 16) break;
      got[got_n] = rd_data_o;
      got_n++;
      rd_en_i = 1'b1;
      @(negedge clk_i);
      rd_en_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(2'd2, s);
    check(s == 0, "R10 status", s, 0);
    check(!rd_valid_o, "R10 fifo empty", 32'(rd_valid_o), 0);
    check(!ack_o, "R10 ack low", 32'(ack_o), 0);
  endtask

  task automatic t_ext_w8();
    int c, a0;
    logic [31:0] s;
    setup(0, 3, 0, 1, 6);
    a0 = ack_tot;
    trig_pulse(2);  // R9 two-cycle pulse
    strobe(32'hABCD_EF11); strobe(32'h1234_5622); strobe(32'hFFFF_FF33);
    strobe(32'h0000_0044); strobe(32'h9999_9955); strobe(32'h7777_7766);
    wait_done(c);
    rd(2'd2, s);
    check(s[0], "R4 done after 6", s, 1);
    check(ack_tot - a0 == 6, "R6 ack per sample", 32'(ack_tot - a0), 6);
    drain();
    check(got_n == 2, "R5 word count w8", 32'(got_n), 2);
    check(got[0] == 32'h4433_2211, "R3 w8 packing", got[0], 32'h4433_2211);
    check(got[1] == 32'h0000_6655, "R5 zero pad", got[1], 32'h0000_6655);
  endtask

  task automatic t_ext_w16();
    int c, a0;
    setup(0, 3, 1, 0, 3);
    a0 = ack_tot;
    trig_pulse(3);
    strobe(32'hDEAD_1111); strobe(32'hBEEF_2222); strobe(32'hCAFE_3333);
    wait_done(c);
    check(ack_tot - a0 == 0, "R6 no ack hs off", 32'(ack_tot - a0), 0);
    drain();
    check(got_n == 2, "R3 word count w16", 32'(got_n), 2);
    check(got[0] == 32'h2222_1111, "R3 w16 packing", got[0], 32'h2222_1111);
    check(got[1] == 32'h0000_3333, "R5 w16 pad", got[1], 32'h0000_3333);
  endtask

  task automatic t_rates();
    int cf, cs, a0;
    din_i = 32'h5A5A_A5A5; step(3);
    a0 = ack_tot;
    setup(0, 0, 2, 1, 8);
    trig_pulse(3);
    wait_done(cf);
    check(ack_tot == a0, "R6 no ack internal", 32'(ack_tot - a0), 0);
    drain();
    check(got_n == 8, "R4 fast count", 32'(got_n), 8);
    check(got[7] == 32'h5A5A_A5A5, "R2 fast data", got[7], 32'h5A5A_A5A5);
    setup(0, 1, 2, 0, 8);
    trig_pulse(3);
    wait_done(cs);
    drain();
    check(got_n == 8, "R4 slow count", 32'(got_n), 8);
    check(cs >= cf + 12, "R2 slow slower than fast", 32'(cs), 32'(cf + 12));
  endtask

  task automatic t_pacer();
    int c;
    setup(0, 2, 2, 0, 3);
    trig_pulse(3);
    for (int i = 0; i < 3; i++) begin
      din_i = 32'h1000_0000 + 32'(i); step(4);
      pacer_tick_i = 1'b1; step(1); pacer_tick_i = 1'b0; step(2);
    end
    wait_done(c);
    drain();
    check(got_n == 3, "R2 pacer count", 32'(got_n), 3);
    check(got[2] == 32'h1000_0002, "R2 pacer data", got[2], 32'h1000_0002);
  endtask

  task automatic t_polarity();
    int c;
    logic [31:0] s;
    trig_i = 1'b0; step(4);
    setup(1, 3, 2, 0, 1);
    trig_i = 1'b1; step(5);         // rising: must be ignored
    strobe(32'hBAD0_0001);
    drain();
    check(got_n == 0, "R1 wrong edge ignored", 32'(got_n), 0);
    trig_i = 1'b0; step(5);         // falling: starts capture
    strobe(32'h600D_0002);
    wait_done(c);
    drain();
    check(got_n == 1 && got[0] == 32'h600D_0002, "R1 falling start", got[0], 32'h600D_0002);
    rd(2'd2, s);
    trig_pulse(3);                  // not armed now
    strobe(32'hBAD0_0003);
    drain();
    check(got_n == 0, "R1 unarmed trigger ignored", 32'(got_n), 0);
  endtask

  task automatic t_overflow();
    int c;
    logic [31:0] s;
    setup(0, 3, 2, 0, 10);
    trig_pulse(3);
    for (int i = 0; i < 10; i++) strobe(32'(i));
    wait_done(c);
    rd(2'd2, s);
    check(s[1], "R8 overflow set", s, 32'h2);
    drain();
    check(got_n == 8, "R8 eight kept", 32'(got_n), 8);
    check(got[0] == 0 && got[7] == 7, "R7 order kept", got[7], 7);
    rd(2'd2, s);
    check(s[1], "R8 sticky after drain", s, 32'h2);
    wr(2'd2, 32'h2);
    rd(2'd2, s);
    check(!s[1], "R8 cleared by write", s, 0);
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    t_reset();
    t_ext_w8();
    t_ext_w16();
    t_rates();
    t_pacer();
    t_polarity();
    t_overflow();
    bench_done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!bench_done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule